// File: doc/BRIEF.md
# Chip-Select Range Decoder

This block sits in front of a memory controller and decides which of its chip selects serves a host request. Each chip select owns a window of the 32-bit address space, given by an inclusive lower bound, an inclusive upper bound and an enable bit. Software loads these through a small register write port. For every request the block returns, one clock later, a one-hot chip-select vector, the offset of the address inside the chosen window, and either a hit flag or an error flag.

Two sticky interrupt flags report configuration and traffic problems. One is raised when a request lands in no enabled window; such a request gets no chip select and comes back flagged as an error. The other is raised whenever two enabled windows share any address. The overlap check runs all the time on the programmed windows, not only when requests arrive. Both flags are cleared by writing ones to a status register.

Top module: `csdec_top`

## Requirements
- R1: Register index 3*i holds the lower bound of window i, index 3*i+1 its upper bound, and bit 0 of index 3*i+2 its enable (i = 0..3). A write takes effect for requests sampled from the next clock edge on.
- R2: An address matches window i when the window is enabled and lower <= addr <= upper, compared as unsigned 32-bit values, with both ends inclusive.
- R3: When several windows match, the lowest-numbered one wins. rsp_cs bit i is set for window i, and rsp_cs never has more than one bit set.
- R4: A request sampled with req_valid high at a clock edge produces rsp_valid high for exactly the following cycle. rsp_offset then equals addr minus the lower bound of the chosen window, modulo 2^32.
- R5: A request that matches no window returns rsp_cs = 0, rsp_hit = 0, rsp_err = 1 and rsp_offset = 0. A matching request returns rsp_hit = 1 and rsp_err = 0. When rsp_valid is low, all response outputs are 0.
- R6: irq_miss rises at the same edge as a miss response, and it stays low while no request is made.
- R7: irq_overlap rises one clock edge after the write that makes two enabled, non-empty windows share an address, and it stays set afterwards.
- R8: A disabled window, or an enabled window whose lower bound exceeds its upper bound, matches no address and takes part in no overlap.
- R9: A write to register index 12 clears irq_miss when bit 0 of the data is set and irq_overlap when bit 1 is set. Zero bits have no effect. If the cause is present at the same edge (a miss response, or an overlap that still exists), the flag stays set.
- R10: After reset, all windows are disabled with bounds 0, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request byte address |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_cs | output | 4 | One-hot chip select of the winning window |
| rsp_offset | output | 32 | Address minus winning window's lower bound |
| rsp_hit | output | 1 | Request matched an enabled window |
| rsp_err | output | 1 | Request matched no enabled window |
| irq_miss | output | 1 | Sticky flag: a request missed every window |
| irq_overlap | output | 1 | Sticky flag: two enabled windows share addresses |

## Verification
Requests hit both inclusive ends of each window and the top of the address space. This separates a correct unsigned inclusive compare from a signed or exclusive one. Addresses inside a disabled window and inside an enabled but inverted window must miss, which shows that the enable and the empty-window rule are honoured. A window placed inside a lower-numbered one exposes both the priority choice and the one-clock timing of the overlap flag. Clear writes are issued with the wrong bit set, with the cause gone, and with the cause still present, to separate write-one-to-clear from plain clearing and from clear-wins behaviour.

// File: rtl/cs_decode_pkg.sv
`timescale 1ns/1ps
// Package: shared address width and the per-window configuration record
// used by every module of the chip-select range decoder.
package cs_decode_pkg;
    parameter int CSD_AW = 32;

    typedef struct packed {
        logic              en;
        logic [CSD_AW-1:0] lower;
        logic [CSD_AW-1:0] upper;
    } cs_window_t;
endpackage

// File: rtl/cs_window_regs.sv
`timescale 1ns/1ps
// Module: cs_window_regs
// Holds the lower bound, upper bound and enable of each window.
// Assumes three consecutive register indices per window (lower, upper,
// control) starting at index 0. Indices beyond them are ignored here.
module cs_window_regs
    import cs_decode_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] idx,
    input  logic [CSD_AW-1:0] wdata,
    output cs_window_t        win [NUM_CS]
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_win
        localparam logic [REG_AW-1:0] IDX_LO = REG_AW'(3 * i);
        localparam logic [REG_AW-1:0] IDX_HI = REG_AW'(3 * i + 1);
        localparam logic [REG_AW-1:0] IDX_CT = REG_AW'(3 * i + 2);

        // Load the addressed field of this window; reset clears all fields.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win[i] <= '0;
            end else if (we) begin
                if (idx == IDX_LO) win[i].lower <= wdata;
                if (idx == IDX_HI) win[i].upper <= wdata;
                if (idx == IDX_CT) win[i].en    <= wdata[0];
            end
        end
    end
endmodule

// File: rtl/cs_range_match.sv
`timescale 1ns/1ps
// Module: cs_range_match
// Combinational window compare with fixed priority. Assumes bounds are
// inclusive and unsigned. An inverted window (lower > upper) matches
// nothing by the compare itself. The lowest-numbered match wins.
module cs_range_match
    import cs_decode_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  cs_window_t        win [NUM_CS],
    input  logic [CSD_AW-1:0] addr,
    output logic [NUM_CS-1:0] sel,
    output logic              hit,
    output logic [CSD_AW-1:0] offset
);
    logic [NUM_CS-1:0] raw;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
        assign raw[i] = win[i].en && (addr >= win[i].lower) && (addr <= win[i].upper);
    end

    // Pick the lowest-numbered matching window and form its offset.
    always_comb begin
        sel    = '0;
        offset = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (raw[i]) begin
                sel    = '0;
                sel[i] = 1'b1;
                offset = addr - win[i].lower;
            end
        end
    end

    assign hit = |raw;
endmodule

// File: rtl/cs_overlap_check.sv
`timescale 1ns/1ps
// Module: cs_overlap_check
// Combinational pairwise test for shared addresses among enabled,
// non-empty windows. Assumes inclusive bounds. Every pair i<j is checked.
module cs_overlap_check
    import cs_decode_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  cs_window_t win [NUM_CS],
    output logic       overlap
);
    localparam int NPAIR = NUM_CS * NUM_CS;

    logic [NUM_CS-1:0] live;
    logic [NPAIR-1:0]  pair;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_live
        assign live[i] = win[i].en && (win[i].lower <= win[i].upper);
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_row
        for (genvar j = 0; j < NUM_CS; j++) begin : g_col
            if (j > i) begin : g_pair
                assign pair[i*NUM_CS+j] = live[i] && live[j]
                    && (win[i].lower <= win[j].upper)
                    && (win[j].lower <= win[i].upper);
            end else begin : g_none
                assign pair[i*NUM_CS+j] = 1'b0;
            end
        end
    end

    assign overlap = |pair;
endmodule

// File: rtl/csdec_top.sv
`timescale 1ns/1ps
// Module: csdec_top
// Chip-select range decoder. It registers one response per request,
// keeps sticky miss and overlap flags, and clears them through a
// write-one-to-clear status register at index 3*NUM_CS.
// Assumes a synchronous active-low reset and a single clock.
module csdec_top
    import cs_decode_pkg::*;
#(
    parameter  int NUM_CS = 4,
    localparam int REG_AW = $clog2(3 * NUM_CS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_idx,
    input  logic [CSD_AW-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [CSD_AW-1:0] req_addr,
    output logic              rsp_valid,
    output logic [NUM_CS-1:0] rsp_cs,
    output logic [CSD_AW-1:0] rsp_offset,
    output logic              rsp_hit,
    output logic              rsp_err,
    output logic              irq_miss,
    output logic              irq_overlap
);
    localparam logic [REG_AW-1:0] IDX_STAT = REG_AW'(3 * NUM_CS);

    cs_window_t        win [NUM_CS];
    logic [NUM_CS-1:0] m_sel;
    logic              m_hit;
    logic [CSD_AW-1:0] m_off;
    logic              ovl_now;
    logic              stat_wr;
    logic              miss_now;

    cs_window_regs #(.NUM_CS(NUM_CS), .REG_AW(REG_AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .win   (win)
    );

    cs_range_match #(.NUM_CS(NUM_CS)) u_match (
        .win    (win),
        .addr   (req_addr),
        .sel    (m_sel),
        .hit    (m_hit),
        .offset (m_off)
    );

    cs_overlap_check #(.NUM_CS(NUM_CS)) u_ovl (
        .win     (win),
        .overlap (ovl_now)
    );

    assign stat_wr  = cfg_we && (cfg_idx == IDX_STAT);
    assign miss_now = req_valid && !m_hit;

    // Register the decode result for one cycle; zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid  <= 1'b0;
            rsp_cs     <= '0;
            rsp_offset <= '0;
            rsp_hit    <= 1'b0;
            rsp_err    <= 1'b0;
        end else begin
            rsp_valid  <= 1'b1;
            rsp_cs     <= m_sel;
            rsp_offset <= m_off;
            rsp_hit    <= m_hit;
            rsp_err    <= !m_hit;
        end
    end

    // Sticky flags: set by their cause, cleared by a one written; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_miss    <= 1'b0;
            irq_overlap <= 1'b0;
        end else begin
            irq_miss    <= miss_now || (irq_miss    && !(stat_wr && cfg_wdata[0]));
            irq_overlap <= ovl_now  || (irq_overlap && !(stat_wr && cfg_wdata[1]));
        end
    end
endmodule

// File: rtl/csdec_checker.sv
`timescale 1ns/1ps
// Module: csdec_checker
// Protocol and flag properties of csdec_top, observed at its ports.
// Attached to every csdec_top instance through the bind at the end.
module csdec_checker
    import cs_decode_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int REG_AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [REG_AW-1:0] cfg_idx,
    input logic [CSD_AW-1:0] cfg_wdata,
    input logic              req_valid,
    input logic              rsp_valid,
    input logic [NUM_CS-1:0] rsp_cs,
    input logic [CSD_AW-1:0] rsp_offset,
    input logic              rsp_hit,
    input logic              rsp_err,
    input logic              irq_miss,
    input logic              irq_overlap
);
    logic clr_miss, clr_ovl;
    assign clr_miss = cfg_we && (cfg_idx == REG_AW'(3 * NUM_CS)) && cfg_wdata[0];
    assign clr_ovl  = cfg_we && (cfg_idx == REG_AW'(3 * NUM_CS)) && cfg_wdata[1];

    assert_onehot_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_cs));

    assert_resp_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_miss_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_cs == '0 && !rsp_hit && rsp_offset == '0));

    assert_hit_xor_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_err));

    assert_miss_raises_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> irq_miss);

    assert_miss_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_miss && !req_valid) |=> !irq_miss);

    assert_miss_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_miss && !clr_miss) |=> irq_miss);

    assert_overlap_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_overlap && !clr_ovl) |=> irq_overlap);
endmodule

bind csdec_top csdec_checker #(.NUM_CS(NUM_CS), .REG_AW(REG_AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_idx     (cfg_idx),
    .cfg_wdata   (cfg_wdata),
    .req_valid   (req_valid),
    .rsp_valid   (rsp_valid),
    .rsp_cs      (rsp_cs),
    .rsp_offset  (rsp_offset),
    .rsp_hit     (rsp_hit),
    .rsp_err     (rsp_err),
    .irq_miss    (irq_miss),
    .irq_overlap (irq_overlap)
);

// File: tb/csdec_top_test.sv
`timescale 1ns/1ps
// Directed bench for csdec_top: one task per scenario, each checking itself.
module csdec_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [3:0]  rsp_cs;
    logic [31:0] rsp_offset;
    logic        rsp_hit, rsp_err, irq_miss, irq_overlap;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    csdec_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_cs(rsp_cs), .rsp_offset(rsp_offset),
        .rsp_hit(rsp_hit), .rsp_err(rsp_err), .irq_miss(irq_miss),
        .irq_overlap(irq_overlap)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic set_win(input int i, input logic [31:0] lo, input logic [31:0] hi, input logic en);
        wr(4'(3*i), lo);
        wr(4'(3*i+1), hi);
        wr(4'(3*i+2), {31'b0, en});
    endtask

    // Issue one request and check the response one edge later.
    task automatic req(input string tag, input logic [31:0] a, input logic [3:0] cs,
                       input logic [31:0] off, input logic hit);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(posedge clk); #1;
        req_valid = 1'b0;
        check({tag, " valid"},  64'(rsp_valid),  64'd1);
        check({tag, " cs"},     64'(rsp_cs),     64'(cs));
        check({tag, " offset"}, 64'(rsp_offset), 64'(off));
        check({tag, " hit"},    64'(rsp_hit),    64'(hit));
        check({tag, " err"},    64'(rsp_err),    64'(!hit));
        if (!hit) check({tag, " irq_miss"}, 64'(irq_miss), 64'd1);
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R10 rsp_valid", 64'(rsp_valid), 0);
        check("R10 rsp_cs", 64'(rsp_cs), 0);
        check("R10 irq_miss", 64'(irq_miss), 0);
        check("R10 irq_overlap", 64'(irq_overlap), 0);
        // R8/R10: all windows disabled, so address 0 misses.
        req("R10 disabled miss", 32'h0, 4'b0000, 32'h0, 1'b0);
        @(posedge clk); #1;
        check("R4 single-cycle rsp", 64'(rsp_valid), 0);
        check("R5 idle err", 64'(rsp_err), 0);
        wr(4'd12, 32'h1);
        check("R9 clear miss", 64'(irq_miss), 0);
    endtask

    task automatic t_basic;
        set_win(0, 32'h0000_0000, 32'h0FFF_FFFF, 1'b1);
        set_win(1, 32'h1000_0000, 32'h1FFF_FFFF, 1'b1);
        set_win(2, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
        set_win(3, 32'h0800_0000, 32'h2FFF_FFFF, 1'b0);
        @(posedge clk); #1;
        check("R8 disabled no overlap", 64'(irq_overlap), 0);
        req("R2 low end cs0",   32'h0000_0000, 4'b0001, 32'h0,         1'b1);
        req("R2 high end cs0",  32'h0FFF_FFFF, 4'b0001, 32'h0FFF_FFFF, 1'b1);
        req("R1 low end cs1",   32'h1000_0000, 4'b0010, 32'h0,         1'b1);
        req("R4 offset cs1",    32'h1234_5678, 4'b0010, 32'h0234_5678, 1'b1);
        req("R2 unsigned top",  32'hFFFF_FFFF, 4'b0100, 32'h7FFF_FFFF, 1'b1);
        req("R2 cs2 low end",   32'h8000_0000, 4'b0100, 32'h0,         1'b1);
        req("R8 disabled cs3",  32'h2000_0010, 4'b0000, 32'h0,         1'b0);
        req("R5 gap miss",      32'h7FFF_FFFF, 4'b0000, 32'h0,         1'b0);
    endtask

    task automatic t_miss_flag;
        // irq_miss set from previous task; a hit keeps it.
        req("R9 sticky after hit", 32'h0000_0040, 4'b0001, 32'h40, 1'b1);
        check("R9 miss sticky", 64'(irq_miss), 1);
        wr(4'd12, 32'h2);
        check("R9 wrong bit no clear", 64'(irq_miss), 1);
        wr(4'd12, 32'h0);
        check("R9 zero write no clear", 64'(irq_miss), 1);
        wr(4'd12, 32'h1);
        check("R9 clear miss bit0", 64'(irq_miss), 0);
        repeat (2) @(posedge clk); #1;
        check("R6 stays low idle", 64'(irq_miss), 0);
        // Miss and clear at the same edge: set wins.
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h6000_0000;
        cfg_we = 1'b1; cfg_idx = 4'd12; cfg_wdata = 32'h1;
        @(posedge clk); #1;
        req_valid = 1'b0; cfg_we = 1'b0;
        check("R9 set beats clear", 64'(irq_miss), 1);
        check("R6 miss err", 64'(rsp_err), 1);
        wr(4'd12, 32'h1);
        check("R9 clear again", 64'(irq_miss), 0);
    endtask

    task automatic t_empty;
        set_win(3, 32'h3000_0000, 32'h2FFF_FFFF, 1'b1);
        @(posedge clk); #1;
        check("R8 empty no overlap", 64'(irq_overlap), 0);
        req("R8 empty window miss", 32'h3000_0000, 4'b0000, 32'h0, 1'b0);
        wr(4'd12, 32'h1);
    endtask

    task automatic t_overlap;
        wr(4'd11, 32'h0);
        wr(4'd9,  32'h1800_0000);
        wr(4'd10, 32'h1800_00FF);
        check("R7 no overlap while disabled", 64'(irq_overlap), 0);
        wr(4'd11, 32'h1);
        check("R7 not yet at write edge", 64'(irq_overlap), 0);
        @(posedge clk); #1;
        check("R7 overlap one clock later", 64'(irq_overlap), 1);
        req("R3 lowest wins", 32'h1800_0010, 4'b0010, 32'h0800_0010, 1'b1);
        req("R1 cs3 limit applies", 32'h1800_0100, 4'b0010, 32'h0800_0100, 1'b1);
        wr(4'd12, 32'h2);
        check("R9 overlap persists", 64'(irq_overlap), 1);
        wr(4'd11, 32'h0);
        @(posedge clk); #1;
        check("R7 sticky after removal", 64'(irq_overlap), 1);
        wr(4'd12, 32'h2);
        check("R9 clear overlap bit1", 64'(irq_overlap), 0);
        check("R9 miss untouched", 64'(irq_miss), 0);
        // Higher window now alone covers 0x3000_0000 after disabling cs1 and moving cs3.
        set_win(3, 32'h1800_0000, 32'h3000_0000, 1'b1);
        @(posedge clk); #1;
        check("R7 overlap with cs1", 64'(irq_overlap), 1);
        wr(4'd5, 32'h0);
        wr(4'd12, 32'h2);
        @(posedge clk); #1;
        check("R8 disabled cs1 clears cause", 64'(irq_overlap), 0);
        req("R3 next window takes over", 32'h1800_0004, 4'b1000, 32'h4, 1'b1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_miss_flag();
        t_empty();
        t_overlap();
        repeat (2) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule